// File: doc/BRIEF.md
# Pipelined 8-Point Inverse DCT Butterfly

This block computes one 1-D 8-point inverse discrete cosine transform per clock on signed 32-bit samples. Eight frequency coefficients enter on a single wide bus with a valid strobe. Eight spatial samples leave four clock cycles later. The datapath is a four-stage butterfly network. The first stage performs four odd-half rotations and four even-half rotations. The second stage forms add/subtract pairs. The third stage applies one shared cos(pi/4) rotation. The last stage is a symmetric output butterfly.

Every constant product is accumulated at 64 bits, then rounded half-up and arithmetically shifted right by 14. The result is then truncated back to 32 bits, so inputs in the 12-bit pixel-depth range cannot overflow a product. A caller that knows only the four low-frequency coefficients are non-zero can raise the sparse strobe. The upper four coefficient lanes are then forced to zero before any multiply. Row/column sequencing and transposition belong to the surrounding logic.

Top module: `idct8_butterfly`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_smp` is all zero until the first result arrives.
- R2: A block accepted with `in_valid` high at a rising edge appears on `out_smp` with `out_valid` high after exactly four rising edges. A new block may be accepted on every clock.
- R3: With coefficients x0..x7 (lane i of a bus at bits 32*i+31:32*i), the odd terms are o4 = RS(x1*3196 - x7*16069), o5 = RS(x5*13623 + x3*9102), o6 = RS(x3*13623 - x5*9102) and o7 = RS(x1*16069 + x7*3196). RS(v) = floor((v + 8192) / 16384), truncated to 32 bits.
- R4: The even terms are e0 = RS((x0 + x4)*11585), e1 = RS((x0 - x4)*11585), e2 = RS(x2*6270 - x6*15137) and e3 = RS(x2*15137 + x6*6270). Their pair sums are m0 = e0+e3, m1 = e1+e2, m2 = e1-e2 and m3 = e0-e3, all in 32-bit wrap-around arithmetic.
- R5: The odd pairs are p4 = o4+o5, p5 = o4-o5, p6 = o7-o6 and p7 = o7+o6. The shared rotation gives r5 = RS((p6 - p5)*11585) and r6 = RS((p6 + p5)*11585).
- R6: The output lanes are y0 = m0+p7, y1 = m1+r6, y2 = m2+r5, y3 = m3+p4, y4 = m3-p4, y5 = m2-r5, y6 = m1-r6 and y7 = m0-p7, each wrapping at 32 bits.
- R7: Rounding is half-up toward positive infinity for both signs: +8192 is added before the shift by 14.
- R8: Products and their sums are formed at 64 bits before the shift. Coefficients anywhere in the 32-bit range give results equal to the exact 64-bit computation truncated to 32 bits.
- R9: When `in_sparse` is high with `in_valid`, lanes 4..7 of `in_coef` are ignored and the result equals that of the same block with those lanes zero.
- R10: While no new result is delivered, `out_smp` holds the last delivered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Accept the coefficients on `in_coef` this cycle |
| in_sparse | input | 1 | Treat coefficient lanes 4..7 as zero |
| in_coef | input | 256 | Eight signed 32-bit coefficients, lane i at bits 32*i+31:32*i |
| out_valid | output | 1 | `out_smp` carries a new result this cycle |
| out_smp | output | 256 | Eight signed 32-bit samples, lane i at bits 32*i+31:32*i |

## Verification
The embedded properties assume `in_valid`, `in_sparse` and `in_coef` are known values at every rising edge once the internal reset has been released. They also assume `in_valid` is held low during reset, so that the four-cycle look-back for the latency and output-sum checks never reaches undefined history. The stimulus follows both rules. It drives inputs only on falling edges, keeps `in_valid` low through reset and the two-cycle release window, and supplies fully defined coefficient words, including the ignored upper lanes in sparse mode.

// File: rtl/idct8_pkg.sv
`timescale 1ns/1ps
package idct8_pkg;
  localparam int N_PT  = 8;
  localparam int N_STG = 4;

  // Cosine constants scaled by 2^14
  localparam int K4  = 16069;
  localparam int K8  = 15137;
  localparam int K12 = 13623;
  localparam int K16 = 11585;
  localparam int K20 = 9102;
  localparam int K24 = 6270;
  localparam int K28 = 3196;

  // First-stage rotator r computes y = x[sel_a]*ka + x[sel_b]*kb.
  // r = 0..3 : odd terms o4..o7, r = 4..7 : even terms e0..e3
  function automatic int rot1_sel_a(input int r);
    case (r)
      0, 3:    return 1;
      1, 2:    return 5;
      4, 5:    return 0;
      default: return 2;
    endcase
  endfunction

  function automatic int rot1_sel_b(input int r);
    case (r)
      0, 3:    return 7;
      1, 2:    return 3;
      4, 5:    return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int rot1_ka(input int r);
    case (r)
      0:       return K28;
      1:       return K12;
      2:       return -K20;
      3:       return K4;
      4, 5:    return K16;
      6:       return K24;
      default: return K8;
    endcase
  endfunction

  function automatic int rot1_kb(input int r);
    case (r)
      0:       return -K4;
      1:       return K20;
      2:       return K12;
      3:       return K28;
      4:       return K16;
      5:       return -K16;
      6:       return -K8;
      default: return K24;
    endcase
  endfunction

  // Third-stage shared rotation: lane 5 = (p6 - p5)*K16, lane 6 = (p6 + p5)*K16
  function automatic int rot3_kb(input int lane);
    return (lane == 5) ? -K16 : K16;
  endfunction
endpackage

// File: rtl/idct8_rst_sync.sv
`timescale 1ns/1ps
module idct8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/idct8_rotator.sv
`timescale 1ns/1ps
module idct8_rotator #(
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 64,
  parameter int FRAC_BITS = 14,
  parameter int KA        = 0,
  parameter int KB        = 0
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] KA_W = ACC_W'(KA);
  localparam logic signed [ACC_W-1:0] KB_W = ACC_W'(KB);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_BITS - 1);

  logic signed [ACC_W-1:0] a_w, b_w, acc;

  always_comb begin
    a_w = {{(ACC_W-DATA_W){a_i[DATA_W-1]}}, a_i};
    b_w = {{(ACC_W-DATA_W){b_i[DATA_W-1]}}, b_i};
    acc = a_w * KA_W + b_w * KB_W + HALF;
    y_o = DATA_W'(acc >>> FRAC_BITS);
  end
endmodule

// File: rtl/idct8_stage_reg.sv
`timescale 1ns/1ps
module idct8_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;

  always_comb q_nxt = en_i ? d_i : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/idct8_butterfly.sv
`timescale 1ns/1ps
module idct8_butterfly
  import idct8_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 64,
  parameter int FRAC_BITS = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sparse,
  input  logic [N_PT*DATA_W-1:0]   in_coef,
  output logic                     out_valid,
  output logic [N_PT*DATA_W-1:0]   out_smp
);
  localparam int VEC_W   = N_PT * DATA_W;
  localparam int HALF_PT = N_PT / 2;

  logic rst_q_n;

  idct8_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // ---------------- valid chain ----------------
  logic [N_STG-1:0] vld_q, vld_nxt;

  always_comb vld_nxt = {vld_q[N_STG-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= '0;
    else          vld_q <= vld_nxt;
  end

  assign out_valid = vld_q[N_STG-1];

  // ---------------- stage registers ----------------
  logic [N_STG-1:0][VEC_W-1:0] bus_d, bus_q;

  genvar gs;
  generate
    for (gs = 0; gs < N_STG; gs++) begin : g_stage
      idct8_stage_reg #(.W(VEC_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_q_n),
        .en_i  (vld_nxt[gs]),
        .d_i   (bus_d[gs]),
        .q_o   (bus_q[gs])
      );
    end
  endgenerate

  assign out_smp = bus_q[N_STG-1];

  // ---------------- lane views ----------------
  logic signed [DATA_W-1:0] coef [N_PT];
  logic signed [DATA_W-1:0] eff  [N_PT];
  logic signed [DATA_W-1:0] sa_d [N_PT];
  logic signed [DATA_W-1:0] sa_q [N_PT];
  logic signed [DATA_W-1:0] sb_d [N_PT];
  logic signed [DATA_W-1:0] sb_q [N_PT];
  logic signed [DATA_W-1:0] sc_d [N_PT];
  logic signed [DATA_W-1:0] sc_q [N_PT];
  logic signed [DATA_W-1:0] sd_d [N_PT];

  genvar gl;
  generate
    for (gl = 0; gl < N_PT; gl++) begin : g_lane
      assign coef[gl] = in_coef[gl*DATA_W +: DATA_W];
      if (gl >= HALF_PT) begin : g_hi
        assign eff[gl] = in_sparse ? '0 : coef[gl];
      end else begin : g_lo
        assign eff[gl] = coef[gl];
      end
      assign bus_d[0][gl*DATA_W +: DATA_W] = sa_d[gl];
      assign sa_q[gl]                      = bus_q[0][gl*DATA_W +: DATA_W];
      assign bus_d[1][gl*DATA_W +: DATA_W] = sb_d[gl];
      assign sb_q[gl]                      = bus_q[1][gl*DATA_W +: DATA_W];
      assign bus_d[2][gl*DATA_W +: DATA_W] = sc_d[gl];
      assign sc_q[gl]                      = bus_q[2][gl*DATA_W +: DATA_W];
      assign bus_d[3][gl*DATA_W +: DATA_W] = sd_d[gl];
    end
  endgenerate

  // ---------------- stage 1: eight rotations ----------------
  // sa lanes: 0..3 = o4..o7, 4..7 = e0..e3
  genvar gr;
  generate
    for (gr = 0; gr < N_PT; gr++) begin : g_rot1
      localparam int SEL_A = rot1_sel_a(gr);
      localparam int SEL_B = rot1_sel_b(gr);
      idct8_rotator #(
        .DATA_W (DATA_W), .ACC_W (ACC_W), .FRAC_BITS (FRAC_BITS),
        .KA (rot1_ka(gr)), .KB (rot1_kb(gr))
      ) u_rot (
        .a_i (eff[SEL_A]),
        .b_i (eff[SEL_B]),
        .y_o (sa_d[gr])
      );
    end
  endgenerate

  // ---------------- stage 2: add/subtract pairs ----------------
  // sb lanes: 0..3 = m0..m3, 4..7 = p4..p7
  always_comb begin
    sb_d[0] = sa_q[4] + sa_q[7];
    sb_d[1] = sa_q[5] + sa_q[6];
    sb_d[2] = sa_q[5] - sa_q[6];
    sb_d[3] = sa_q[4] - sa_q[7];
    sb_d[4] = sa_q[0] + sa_q[1];
    sb_d[5] = sa_q[0] - sa_q[1];
    sb_d[6] = sa_q[3] - sa_q[2];
    sb_d[7] = sa_q[3] + sa_q[2];
  end

  // ---------------- stage 3: shared cos(pi/4) rotation ----------------
  // sc lanes: 0..3 = m0..m3, 4 = p4, 5 = r5, 6 = r6, 7 = p7
  generate
    for (gl = 0; gl < N_PT; gl++) begin : g_rot3
      if (gl == 5 || gl == 6) begin : g_mul
        idct8_rotator #(
          .DATA_W (DATA_W), .ACC_W (ACC_W), .FRAC_BITS (FRAC_BITS),
          .KA (K16), .KB (rot3_kb(gl))
        ) u_rot (
          .a_i (sb_q[6]),
          .b_i (sb_q[5]),
          .y_o (sc_d[gl])
        );
      end else begin : g_pass
        assign sc_d[gl] = sb_q[gl];
      end
    end
  endgenerate

  // ---------------- stage 4: mirrored output butterfly ----------------
  genvar gk;
  generate
    for (gk = 0; gk < HALF_PT; gk++) begin : g_out
      assign sd_d[gk]          = sc_q[gk] + sc_q[N_PT-1-gk];
      assign sd_d[N_PT-1-gk]   = sc_q[gk] - sc_q[N_PT-1-gk];
    end
  endgenerate

  // ---------------- embedded checks ----------------
  logic [DATA_W-1:0] chk_even_sum, chk_odd_sum;
  assign chk_even_sum = out_smp[0*DATA_W +: DATA_W] + out_smp[7*DATA_W +: DATA_W]
                      + out_smp[3*DATA_W +: DATA_W] + out_smp[4*DATA_W +: DATA_W];
  assign chk_odd_sum  = out_smp[1*DATA_W +: DATA_W] + out_smp[6*DATA_W +: DATA_W]
                      + out_smp[2*DATA_W +: DATA_W] + out_smp[5*DATA_W +: DATA_W];

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> $past(in_valid, 4));  // R2

  AST_ODD_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && coef[1] == '0 && coef[3] == '0 &&
     (in_sparse || (coef[5] == '0 && coef[7] == '0)))
    |=> (sa_q[0] == '0 && sa_q[1] == '0 && sa_q[2] == '0 && sa_q[3] == '0));  // R3

  AST_SPARSE_EVEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_sparse) |=> (sa_q[4] == sa_q[5]));  // R9

  AST_OUT_SUMS: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> (chk_even_sum == ($past(sa_q[4], 3) << 2) &&
                   chk_odd_sum  == ($past(sa_q[5], 3) << 2)));  // R6
endmodule

// File: tb/idct8_butterfly_tb_top.sv
`timescale 1ns/1ps
module idct8_butterfly_tb_top;
  localparam longint C4 = 16069, C8 = 15137, C12 = 13623, C16 = 11585;
  localparam longint C20 = 9102, C24 = 6270, C28 = 3196;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_sparse;
  logic [255:0] in_coef;
  logic         out_valid;
  logic [255:0] out_smp;

  always #2.5 clk = ~clk;

  idct8_butterfly dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sparse (in_sparse),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_smp   (out_smp)
  );

  typedef struct {
    bit    vld;
    int    smp [8];
    string tag;
  } exp_t;

  exp_t exp_q [$];
  int   last_out [8];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic int rsh(input longint v);
    return int'((v + 64'sd8192) >>> 14);
  endfunction

  function automatic void ref_model(input int c [8], input bit sp, output int y [8]);
    longint x [8];
    int ev0, ev1, ev2, ev3, od4, od5, od6, od7;
    int pa, pb, pc, pd, m0, m1, m2, m3, q5, q6;
    for (int i = 0; i < 8; i++) x[i] = (sp && i >= 4) ? 64'sd0 : longint'(c[i]);
    ev0 = rsh(x[0]*C16 + x[4]*C16);
    ev1 = rsh(x[0]*C16 - x[4]*C16);
    ev2 = rsh(x[2]*C24 - x[6]*C8);
    ev3 = rsh(x[2]*C8  + x[6]*C24);
    od4 = rsh(x[1]*C28 - x[7]*C4);
    od5 = rsh(x[5]*C12 + x[3]*C20);
    od6 = rsh(x[3]*C12 - x[5]*C20);
    od7 = rsh(x[1]*C4  + x[7]*C28);
    pa = od4 + od5;  pb = od4 - od5;  pc = od7 - od6;  pd = od7 + od6;
    m0 = ev0 + ev3;  m1 = ev1 + ev2;  m2 = ev1 - ev2;  m3 = ev0 - ev3;
    q5 = rsh(longint'(pc)*C16 - longint'(pb)*C16);
    q6 = rsh(longint'(pc)*C16 + longint'(pb)*C16);
    y[0] = m0 + pd;  y[7] = m0 - pd;
    y[1] = m1 + q6;  y[6] = m1 - q6;
    y[2] = m2 + q5;  y[5] = m2 - q5;
    y[3] = m3 + pa;  y[4] = m3 - pa;
  endfunction

  task automatic compare_now();
    exp_t e;
    int   want [8];
    int   got;
    bit   bad;
    e   = exp_q.pop_front();
    bad = 1'b0;
    n_cmp++;
    if (out_valid !== e.vld) begin
      $display("FAIL R2 (%s) out_valid got %0b exp %0b", e.tag, out_valid, e.vld);
      bad = 1'b1;
    end
    for (int i = 0; i < 8; i++) want[i] = e.vld ? e.smp[i] : last_out[i];
    for (int i = 0; i < 8; i++) begin
      got = int'(out_smp[i*32 +: 32]);
      if (got !== want[i]) begin
        $display("FAIL %s lane %0d got %0d exp %0d", e.tag, i, got, want[i]);
        bad = 1'b1;
      end
    end
    if (e.vld) for (int i = 0; i < 8; i++) last_out[i] = e.smp[i];
    if (bad) n_bad++;
  endtask

  task automatic step(input bit vld, input bit sp, input int c [8], input string tag);
    exp_t e;
    @(negedge clk);
    compare_now();
    in_valid  = vld;
    in_sparse = sp;
    for (int i = 0; i < 8; i++) in_coef[i*32 +: 32] = c[i];
    e.vld = vld;
    e.tag = vld ? tag : "R10";
    if (vld) ref_model(c, sp, e.smp);
    else for (int i = 0; i < 8; i++) e.smp[i] = 0;
    exp_q.push_back(e);
  endtask

  function automatic int small_rand();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic idle(input int n);
    int z [8];
    for (int i = 0; i < 8; i++) z[i] = 0;
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, z, "R10");
  endtask

  initial begin
    int c [8];
    exp_t e0;
    void'($urandom(32'd7));
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sparse = 1'b0;
    in_coef   = '0;
    for (int i = 0; i < 8; i++) last_out[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || out_smp !== '0) begin
      $display("FAIL R1 after reset got valid=%0b smp=%h exp valid=0 smp=0", out_valid, out_smp);
      n_bad++;
    end
    e0.vld = 1'b0;
    e0.tag = "R1";
    for (int i = 0; i < 8; i++) e0.smp[i] = 0;
    for (int k = 0; k < 4; k++) exp_q.push_back(e0);

    // R3: odd coefficients only
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) c[i] = (i % 2 == 1) ? small_rand() : 0;
      step(1'b1, 1'b0, c, "R3");
    end
    // R4: even coefficients only
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) c[i] = (i % 2 == 0) ? small_rand() : 0;
      step(1'b1, 1'b0, c, "R4");
    end
    idle(3);
    // R5: only x3 and x5 drive the shared rotation
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) c[i] = (i == 3 || i == 5) ? small_rand() : 0;
      step(1'b1, 1'b0, c, "R5");
    end
    // R7: small DC values straddle the rounding point for both signs
    for (int v = -20; v <= 20; v++) begin
      for (int i = 0; i < 8; i++) c[i] = 0;
      c[0] = v;
      step(1'b1, 1'b0, c, "R7");
    end
    idle(2);
    // R8: full 32-bit range coefficients
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 8; i++) c[i] = int'($urandom);
      step(1'b1, 1'b0, c, "R8");
    end
    // R9: sparse mode with non-zero garbage in the upper lanes
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 8; i++) c[i] = (i < 4) ? small_rand() : int'($urandom);
      step(1'b1, 1'b1, c, "R9");
    end
    idle(5);
    // R6: general blocks, back-to-back
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 8; i++) c[i] = small_rand();
      step(1'b1, 1'b0, c, "R6");
    end
    // R2 / R10: sparse stream with irregular gaps
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 8; i++) c[i] = small_rand();
      step(1'b1, (k % 3 == 0), c, "R2");
      if (k % 4 == 1) idle(k % 5 + 1);
    end
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule